// File: doc/BRIEF.md
# Decade-Programmable Timer Period Extender

This block sits after the comparator and set/reset latch of an RC timer core. It stretches the core's timing by a power of ten. It samples the core latch output (`core_q`) on the system clock and counts its rising edges in a chain of six cascaded BCD decades. From that count it drives the timer output and the discharge-enable control. A three-bit ratio field in the configuration byte chooses how many core edges make one output interval: 10, 100, 1 000, 10 000, 100 000 or 1 000 000. Two codes of that field instead bypass the counter.

In bypass, a 2:1 output mux routes the core latch straight to the output and the counter stays cleared. With the counter engaged, a mode bit chooses between two behaviours. In monostable mode, a falling edge on the active-low trigger starts a pulse that lasts N core edges. In astable mode, the output free-runs and toggles every N core edges. The active-low reset is asynchronous and overrides everything else. The configuration byte is echoed back with its top bit forced to 1.

Top module: `period_extender`

## Requirements
- R1: Ratio field `cfg[2:0]` codes 1 to 6 select N = 10^code core rising edges per output interval (code 1 gives 10, code 6 gives 1 000 000). Each BCD decade only holds the values 0 to 9, and the decades at or above the selected code stay at zero.
- R2: Ratio codes 0 and 7 select bypass. In bypass `out_q` equals `core_q` in the same cycle, without passing through a register, and the counter is held cleared.
- R3: In bypass, the mode bit `cfg[3]` and the trigger input have no effect on `out_q`.
- R4: Monostable operation is selected with `cfg[3]=1` and a ratio code of 1 to 6. A trigger falling edge, sampled at clock edge k, raises `out_q` after edge k. Rising core edges that are sampled in the same cycle as the trigger edge are not counted. `out_q` drops at the clock edge that samples the N-th counted core rising edge, and the block then waits for the next trigger.
- R5: A trigger falling edge that arrives while a monostable pulse is high is ignored, and the count continues.
- R6: Astable operation is selected with `cfg[3]=0` and a ratio code of 1 to 6. Starting low after reset, `out_q` toggles at every N-th sampled core rising edge and free-runs.
- R7: `dis_en` equals `out_q` at all times.
- R8: While `rst_n` is low, `out_q` and `dis_en` are 0 immediately, without waiting for a clock, and the counter and edge detectors are cleared.
- R9: `cfg[6:4]` do not affect the outputs. `cfg_echo` equals `cfg` with bit 7 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_n | input | 1 | Trigger, active low; its falling edge starts a monostable pulse |
| core_q | input | 1 | Output of the core set/reset latch |
| cfg | input | 8 | Configuration byte: [2:0] ratio, [3] mode (1 = monostable), [6:4] analog selects and a spare bit |
| out_q | output | 1 | Timer output |
| dis_en | output | 1 | Discharge switch enable; follows out_q |
| cfg_echo | output | 8 | Configuration readback, bit 7 forced to 1 |

## Verification
The hardest state to reach is the terminal count of a higher decade while a retrigger is pending. For N = 1 000 this takes a thousand sampled core edges. It is reached by toggling `core_q` every clock cycle in astable mode, and by issuing retriggers partway through long monostable pulses. A behavioural model tracks the count as a plain integer compared against 10^code. The output is compared against that model on every cycle, across bypass, both extended modes and an asynchronous reset in mid-count.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int NUM_DEC = 6;
  localparam int CODE_W  = 3;
  localparam int DIG_W   = 4;
  localparam int DIG_MAX = 9;

  typedef enum logic {
    OP_ASTABLE    = 1'b0,
    OP_MONOSTABLE = 1'b1
  } op_mode_t;

  function automatic logic code_bypass(input logic [CODE_W-1:0] code);
    return (code == '0) || (code == '1);
  endfunction
endpackage

// File: rtl/pe_bcd_digit.sv
module pe_bcd_digit #(
  parameter int DW   = 4,
  parameter int MAXV = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [DW-1:0] val,
  output logic          at_max
);
  assign at_max = (val == DW'(MAXV));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val <= '0;
    else if (clr) val <= '0;
    else if (inc) val <= at_max ? '0 : val + 1'b1;
  end

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    val <= DW'(MAXV)); // R1
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (val == '0)); // R1
endmodule

// File: rtl/pe_decade_chain.sv
module pe_decade_chain #(
  parameter int NUM_DEC = 6,
  parameter int SEL_W   = 3,
  parameter int DIG_W   = 4,
  parameter int DIG_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_all,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             last,
  output logic             all_zero
);
  logic [NUM_DEC-1:0] nine;
  logic [NUM_DEC-1:0] zero;
  logic [NUM_DEC:0]   carry;

  assign carry[0] = step;

  generate
    for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
      logic [DIG_W-1:0] v;
      logic             above;
      logic             clr_i;
      assign above    = (SEL_W'(i) >= sel);
      assign clr_i    = clr_all | (step & last) | above;
      assign carry[i+1] = carry[i] & nine[i];
      assign zero[i]  = (v == '0);

      pe_bcd_digit #(.DW(DIG_W), .MAXV(DIG_MAX)) u_dig (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_i),
        .inc   (carry[i]),
        .val   (v),
        .at_max(nine[i])
      );
    end
  endgenerate

  always_comb begin
    last = 1'b1;
    for (int i = 0; i < NUM_DEC; i++) begin
      if (i < int'(sel)) last = last & nine[i];
    end
  end

  assign all_zero = &zero;
endmodule

// File: rtl/period_extender.sv
module period_extender
  import pe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_n,
  input  logic       core_q,
  input  logic [7:0] cfg,
  output logic       out_q,
  output logic       dis_en,
  output logic [7:0] cfg_echo
);
  logic [CODE_W-1:0] code;
  op_mode_t          mode;
  logic              byp;
  logic              core_d, trig_d;
  logic              core_rise, trig_fall;
  logic              run;
  logic              step, last, cnt_zero, cnt_clr;

  assign code = cfg[CODE_W-1:0];
  assign mode = op_mode_t'(cfg[3]);
  assign byp  = code_bypass(code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_d <= 1'b0;
      trig_d <= 1'b1;
    end else begin
      core_d <= core_q;
      trig_d <= trig_n;
    end
  end

  assign core_rise = core_q & ~core_d;
  assign trig_fall = trig_d & ~trig_n;

  assign step    = core_rise & ~byp & ((mode == OP_ASTABLE) | run);
  assign cnt_clr = byp | ((mode == OP_MONOSTABLE) & ~run);

  pe_decade_chain #(
    .NUM_DEC(NUM_DEC), .SEL_W(CODE_W), .DIG_W(DIG_W), .DIG_MAX(DIG_MAX)
  ) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_all (cnt_clr),
    .step    (step),
    .sel     (code),
    .last    (last),
    .all_zero(cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    run <= 1'b0;
    else if (byp)                  run <= 1'b0;
    else if (mode == OP_ASTABLE) begin
      if (step && last)            run <= ~run;
    end else if (!run) begin
      if (trig_fall)               run <= 1'b1;
    end else if (step && last)     run <= 1'b0;
  end

  assign out_q    = rst_n & (byp ? core_q : run);
  assign dis_en   = out_q;
  assign cfg_echo = {1'b1, cfg[6:0]};

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    byp |=> cnt_zero); // R2
  AST_MONO_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && mode == OP_MONOSTABLE && run && step && last) |=> !run); // R4
  AST_MONO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && mode == OP_MONOSTABLE && run && !(step && last)) |=> run); // R5
  AST_ASTABLE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && mode == OP_ASTABLE && !(step && last)) |=> $stable(run)); // R6
endmodule

// File: tb/period_extender_test.sv
module period_extender_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_n = 1'b1;
  logic       core_q = 1'b0;
  logic [7:0] cfg = 8'h00;
  logic       out_q, dis_en;
  logic [7:0] cfg_echo;

  int    n_chk = 0, n_bad = 0, cyc = 0, half = 0, ph = 0;
  bit    cmp_on = 1'b0;
  string cur_req = "R8";

  int m_run = 0, m_cnt = 0, m_cp = 0, m_tp = 1;

  period_extender uut (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .core_q(core_q),
    .cfg(cfg), .out_q(out_q), .dis_en(dis_en), .cfg_echo(cfg_echo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_byp(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd7);
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_cp = 0; m_tp = 1;
    end else begin
      int  n;
      bit  rise, fall;
      rise = core_q && (m_cp == 0);
      fall = !trig_n && (m_tp == 1);
      m_cp = core_q; m_tp = trig_n;
      n = 10 ** int'(cfg[2:0]);
      if (is_byp(cfg[2:0])) begin
        m_run = 0; m_cnt = 0;
      end else if (!cfg[3]) begin
        if (rise) begin
          if (m_cnt == n - 1) begin m_cnt = 0; m_run = 1 - m_run; end
          else m_cnt++;
        end
      end else if (m_run == 0) begin
        m_cnt = 0;
        if (fall) m_run = 1;
      end else if (rise) begin
        if (m_cnt == n - 1) begin m_cnt = 0; m_run = 0; end
        else m_cnt++;
      end
    end
  end

  function automatic int exp_out();
    if (!rst_n) return 0;
    if (is_byp(cfg[2:0])) return int'(core_q);
    return m_run;
  endfunction

  always @(negedge clk) begin
    if (cmp_on) begin
      check(out_q == exp_out(), cur_req, out_q, exp_out());
      check(dis_en == out_q, "R7", dis_en, out_q);
    end
  end

  // core oscillator driver
  always @(posedge clk) begin
    #1;
    if (half > 0) begin
      ph++;
      if (ph >= half) begin ph = 0; core_q = ~core_q; end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic pulse_trig();
    @(posedge clk); #1 trig_n = 1'b0;
    @(posedge clk); #1 trig_n = 1'b1;
  endtask

  task automatic restart(input logic [7:0] c, input int h, input string req);
    @(posedge clk); #1 rst_n = 1'b0;
    #1 check(out_q == 1'b0 && dis_en == 1'b0, "R8", out_q, 0);
    cfg = c; half = h; cur_req = req;
    @(posedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    wait_cyc(3);
    #1;
    check(out_q == 1'b0, "R8", out_q, 0);
    check(dis_en == 1'b0, "R7", dis_en, 0);
    cfg = 8'h35;
    #1 check(cfg_echo == 8'hB5, "R9", cfg_echo, 8'hB5);
    cfg = 8'h80;
    #1 check(cfg_echo == 8'h80, "R9", cfg_echo, 8'h80);
    cmp_on = 1'b1;

    // R2: bypass code 0, core passes straight through
    restart(8'h00, 3, "R2");
    wait_cyc(40);
    // R3: code 7 with monostable bit and triggers, still bypass
    restart(8'h0F, 2, "R3");
    pulse_trig(); wait_cyc(10); pulse_trig(); wait_cyc(20);

    // R8: async reset in the middle of a monostable pulse
    restart(8'h09, 2, "R8");
    pulse_trig(); wait_cyc(12);
    check(out_q == 1'b1, "R4", out_q, 1);
    @(posedge clk); #2 rst_n = 1'b0;
    #1 check(out_q == 1'b0, "R8", out_q, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R4: monostable N=10, bits 6:4 set (R9)
    restart(8'h79, 2, "R4");
    wait_cyc(5); pulse_trig(); wait_cyc(60);
    pulse_trig(); wait_cyc(60);
    // R5: retrigger while high, N=10
    restart(8'h09, 2, "R5");
    pulse_trig(); wait_cyc(15); pulse_trig(); wait_cyc(10); pulse_trig(); wait_cyc(40);
    // R4/R1: monostable N=100, core toggling every cycle
    restart(8'h0A, 1, "R1");
    pulse_trig(); wait_cyc(90); pulse_trig(); wait_cyc(150);
    pulse_trig(); wait_cyc(250);

    // R6: astable N=10 and N=100
    restart(8'h01, 2, "R6");
    wait_cyc(300);
    restart(8'h42, 1, "R6");
    wait_cyc(700);
    // R1: astable N=1000, several toggles
    restart(8'h03, 1, "R1");
    wait_cyc(6500);
    // R1: monostable N=1000 with retrigger near the terminal count
    restart(8'h0B, 1, "R5");
    pulse_trig(); wait_cyc(1990); pulse_trig(); wait_cyc(100);
    // R1: largest ratio holds high
    restart(8'h0E, 1, "R1");
    pulse_trig(); wait_cyc(3000);
    check(out_q == 1'b1, "R1", out_q, 1);

    cmp_on = 1'b0;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule